// File: doc/BRIEF.md
# Two-Context Fetch Mode Arbiter

This block decides, cycle by cycle, which of two hardware thread contexts may use one shared front-end structure. It keeps a program counter for each context and issues at most one grant per cycle. The grant carries the winning context's ID bit, so whatever the shared structure stores can be tagged with its owner, and the PC of that context.

Which contexts may win depends on a mode machine driven by per-context halt and interrupt pulses. In multi-task mode both contexts compete, and the grant alternates between them. When one context halts, the block moves to the single-task mode of the context that is still running. From then on only that context is served, on every cycle it asks. An interrupt to the halted context brings the block back to multi-task mode. If the last running context halts, both contexts are idle until an interrupt wakes one of them.

Each context's request acts as a valid and its stall acts as ready-low. A context is granted only in a cycle where it requests, is not stalled and is running. A stalled context loses nothing: it simply is not granted, and its PC holds until it is updated through its next-PC port. Halt, interrupt and mode pins are plain control, with no handshake.

Top module: `ctx_fetch_arb`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the mode is multi-task and both PCs equal reset_vec_i. The favoured context is context 0.
- R2: At most one grant is issued per cycle. When gnt_valid_o is 1, gnt_ctx_o names the granted context and gnt_pc_o holds that context's current PC.
- R3: In multi-task mode, when both contexts are eligible, the favoured context wins. After any grant to context c, the favoured context becomes the other context.
- R4: In multi-task mode, when the favoured context is stalled or not requesting, an eligible other context gets the grant.
- R5: mode_o encodes multi-task as 0, single-task context 0 as 1, single-task context 1 as 2 and idle as 3. A halt of one context in multi-task mode moves the mode to the single-task mode of the other context. Halts of both contexts in the same cycle move it to idle. Mode changes take effect on the next clock edge.
- R6: An interrupt to the halted context while in a single-task mode returns the mode to multi-task.
- R7: In a single-task mode, the running context is granted in every cycle in which it requests and is not stalled. The halted context is never granted.
- R8: A halt of the only running context moves the mode to idle, where nothing is granted. In idle, an interrupt to one context enters that context's single-task mode, and interrupts to both enter multi-task mode.
- R9: A pulse on a context's PC update input loads that context's next-PC value at the next edge. Without an update, the PC holds. The two contexts' PCs are independent.
- R10: A halt to a context that is already halted, and an interrupt to a context that is running, have no effect on the mode.
- R11: Whenever at least one running context requests and is not stalled, a grant is issued in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reset_vec_i | input | PCW | PC value loaded into both contexts at reset |
| req_i | input | 2 | Per-context request (valid) |
| stall_i | input | 2 | Per-context stall (ready low) |
| halt_i | input | 2 | Per-context halt pulse |
| irq_i | input | 2 | Per-context interrupt pulse |
| pc_upd_i | input | 2 | Per-context PC load strobe |
| pc_nxt0_i | input | PCW | Next PC for context 0 |
| pc_nxt1_i | input | PCW | Next PC for context 1 |
| gnt_valid_o | output | 1 | A grant is issued this cycle |
| gnt_ctx_o | output | 1 | ID of the granted context |
| gnt_pc_o | output | PCW | PC of the granted context |
| mode_o | output | 2 | Current mode (0 multi-task, 1 single-task 0, 2 single-task 1, 3 idle) |

## Verification
Random request and stall patterns with both contexts running show whether the alternation follows the favour bit, including the fallback when only the non-favoured context is eligible. Sparse random halts and interrupts walk the mode machine through every state. This separates correct single-task service from leaks to the halted context, and separates ignored events (a halt to a halted context, an interrupt to a running one) from real transitions. Directed cases cover the reset PCs seen through a grant, a simultaneous double halt, a double interrupt out of idle, and PC updates to one context while the other holds.

// File: rtl/ctx_arb_pkg.sv
package ctx_arb_pkg;
  typedef enum logic [1:0] {
    MODE_MT   = 2'd0,
    MODE_ST0  = 2'd1,
    MODE_ST1  = 2'd2,
    MODE_IDLE = 2'd3
  } arb_mode_e;

  localparam int unsigned NCTX = 2;

  function automatic arb_mode_e mode_of(input logic [NCTX-1:0] run);
    case (run)
      2'b11:   return MODE_MT;
      2'b01:   return MODE_ST0;
      2'b10:   return MODE_ST1;
      default: return MODE_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/ctx_mode_fsm.sv
module ctx_mode_fsm
  import ctx_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCTX-1:0] halt_i,
  input  logic [NCTX-1:0] irq_i,
  output logic [NCTX-1:0] run_o,
  output arb_mode_e       mode_o
);
  logic [NCTX-1:0] run_q;
  logic [NCTX-1:0] run_d;

  // A running context stays running unless halted; a halted one wakes on an interrupt.
  always_comb run_d = (run_q & ~halt_i) | (~run_q & irq_i);

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '1;
    else        run_q <= run_d;
  end

  assign run_o  = run_q;
  assign mode_o = mode_of(run_q);

  assert_halt_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_MT && halt_i == 2'b01) |=> (mode_o == MODE_ST1));
  assert_halt_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_MT && halt_i == 2'b11) |=> (mode_o == MODE_IDLE));
  assert_irq_resume_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_ST0 && irq_i[1] && !halt_i[0]) |=> (mode_o == MODE_MT));
  assert_idle_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_IDLE && irq_i == 2'b10) |=> (mode_o == MODE_ST1));
  assert_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_ST1 && halt_i == 2'b01 && irq_i == 2'b10) |=> (mode_o == MODE_ST1));
endmodule

// File: rtl/ctx_pc_bank.sv
module ctx_pc_bank
  import ctx_arb_pkg::*;
#(
  parameter int unsigned PCW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PCW-1:0]           reset_vec_i,
  input  logic [NCTX-1:0]          upd_i,
  input  logic [NCTX-1:0][PCW-1:0] nxt_i,
  output logic [NCTX-1:0][PCW-1:0] pc_o
);
  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic [PCW-1:0] pc_q;

    always_ff @(posedge clk) begin
      if (!rst_n)        pc_q <= reset_vec_i;
      else if (upd_i[c]) pc_q <= nxt_i[c];
    end

    assign pc_o[c] = pc_q;

    assert_pc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_i[c] && $past(rst_n)) |=> $stable(pc_o[c]));
  end
endmodule

// File: rtl/ctx_grant_pick.sv
module ctx_grant_pick
  import ctx_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCTX-1:0] run_i,
  input  logic [NCTX-1:0] req_i,
  input  logic [NCTX-1:0] stall_i,
  output logic            gnt_valid_o,
  output logic            gnt_ctx_o
);
  logic            fav_q;
  logic [NCTX-1:0] elig;

  always_comb begin
    elig        = req_i & ~stall_i & run_i;
    gnt_valid_o = |elig;
    unique case (elig)
      2'b11:   gnt_ctx_o = fav_q;
      2'b10:   gnt_ctx_o = 1'b1;
      default: gnt_ctx_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           fav_q <= 1'b0;
    else if (gnt_valid_o) fav_q <= ~gnt_ctx_o;
  end

  assert_only_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid_o |-> (run_i[gnt_ctx_o] && req_i[gnt_ctx_o] && !stall_i[gnt_ctx_o]));
  assert_progress_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(run_i & req_i & ~stall_i)) |-> gnt_valid_o);
  assert_alternate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && (run_i & req_i & ~stall_i) == 2'b11) |=>
      (((run_i & req_i & ~stall_i) == 2'b11) |-> (gnt_ctx_o != $past(gnt_ctx_o))));
endmodule

// File: rtl/ctx_fetch_arb.sv
module ctx_fetch_arb
  import ctx_arb_pkg::*;
#(
  parameter int unsigned PCW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PCW-1:0] reset_vec_i,
  input  logic [1:0]     req_i,
  input  logic [1:0]     stall_i,
  input  logic [1:0]     halt_i,
  input  logic [1:0]     irq_i,
  input  logic [1:0]     pc_upd_i,
  input  logic [PCW-1:0] pc_nxt0_i,
  input  logic [PCW-1:0] pc_nxt1_i,
  output logic           gnt_valid_o,
  output logic           gnt_ctx_o,
  output logic [PCW-1:0] gnt_pc_o,
  output logic [1:0]     mode_o
);
  logic [NCTX-1:0]          run;
  arb_mode_e                mode;
  logic [NCTX-1:0][PCW-1:0] pcs;
  logic [NCTX-1:0][PCW-1:0] nxt;

  assign nxt[0] = pc_nxt0_i;
  assign nxt[1] = pc_nxt1_i;

  ctx_mode_fsm u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .halt_i (halt_i),
    .irq_i  (irq_i),
    .run_o  (run),
    .mode_o (mode)
  );

  ctx_pc_bank #(.PCW(PCW)) u_pcs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reset_vec_i (reset_vec_i),
    .upd_i       (pc_upd_i),
    .nxt_i       (nxt),
    .pc_o        (pcs)
  );

  ctx_grant_pick u_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run),
    .req_i       (req_i),
    .stall_i     (stall_i),
    .gnt_valid_o (gnt_valid_o),
    .gnt_ctx_o   (gnt_ctx_o)
  );

  assign gnt_pc_o = pcs[gnt_ctx_o];
  assign mode_o   = mode;

  assert_idle_no_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_IDLE) |-> !gnt_valid_o);
  assert_reset_mode_R1: assert property (@(posedge clk)
    !rst_n |=> (mode_o == MODE_MT));
endmodule

// File: tb/ctx_fetch_arb_test.sv
module ctx_fetch_arb_test;
  localparam int PCW = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam int NCYC = 4000;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [PCW-1:0] reset_vec;
  logic [1:0]     req, stall, halt, irq, upd;
  logic [PCW-1:0] nxt0, nxt1;
  logic           gnt_valid, gnt_ctx;
  logic [PCW-1:0] gnt_pc;
  logic [1:0]     mode;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // bench reference state
  logic [1:0]     m_run;
  logic           m_fav;
  logic [PCW-1:0] m_pc [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_fetch_arb #(.PCW(PCW)) uut (
    .clk(clk), .rst_n(rst_n), .reset_vec_i(reset_vec),
    .req_i(req), .stall_i(stall), .halt_i(halt), .irq_i(irq),
    .pc_upd_i(upd), .pc_nxt0_i(nxt0), .pc_nxt1_i(nxt1),
    .gnt_valid_o(gnt_valid), .gnt_ctx_o(gnt_ctx), .gnt_pc_o(gnt_pc),
    .mode_o(mode)
  );

  function automatic logic [1:0] exp_mode(input logic [1:0] run);
    case (run)
      2'b11:   return 2'd0;
      2'b01:   return 2'd1;
      2'b10:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [1:0] exp_grant(input logic [1:0] run, input logic fav,
                                           input logic [1:0] r, input logic [1:0] s);
    logic [1:0] e;
    e = run & r & ~s;
    if (e == 2'b11)      return {1'b1, fav};
    else if (e == 2'b10) return 2'b11;
    else if (e == 2'b01) return 2'b10;
    else                 return 2'b00;
  endfunction

  task automatic check(input string tag, input logic [PCW-1:0] act, input logic [PCW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // one cycle: inputs already driven at negedge; compare, clock, advance the reference
  task automatic step();
    logic [1:0] g;
    #1;
    g = exp_grant(m_run, m_fav, req, stall);
    check("R2/R3/R4/R7/R11 grant valid", PCW'(gnt_valid), PCW'(g[1]));
    if (g[1]) begin
      check("R2 grant ctx", PCW'(gnt_ctx), PCW'(g[0]));
      check("R2/R9 grant pc", gnt_pc, m_pc[g[0]]);
    end
    check("R5/R6/R8/R10 mode", PCW'(mode), PCW'(exp_mode(m_run)));
    @(posedge clk);
    if (upd[0]) m_pc[0] = nxt0;
    if (upd[1]) m_pc[1] = nxt1;
    m_run = (m_run & ~halt) | (~m_run & irq);
    if (g[1]) m_fav = ~g[0];
    @(negedge clk);
  endtask

  task automatic drive(input logic [1:0] r, input logic [1:0] s,
                       input logic [1:0] h, input logic [1:0] i);
    req = r; stall = s; halt = h; irq = i; upd = 2'b00;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    reset_vec = 32'h0000_1000;
    rst_n = 1'b0; req = 0; stall = 0; halt = 0; irq = 0; upd = 0;
    nxt0 = 0; nxt1 = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_run = 2'b11; m_fav = 1'b0;
    m_pc[0] = reset_vec; m_pc[1] = reset_vec;

    // R1: reset state seen at the ports
    #1;
    check("R1 mode after reset", PCW'(mode), 0);
    check("R1 no grant without request", PCW'(gnt_valid), 0);
    drive(2'b01, 2'b00, 2'b00, 2'b00);   // R1 pc0 through grant
    drive(2'b10, 2'b00, 2'b00, 2'b00);   // R1 pc1 through grant

    // R3: alternation with both eligible
    repeat (4) drive(2'b11, 2'b00, 2'b00, 2'b00);
    // R4: favoured stalled -> other wins
    drive(2'b11, 2'b01, 2'b00, 2'b00);
    drive(2'b11, 2'b01, 2'b00, 2'b00);

    // R9: update ctx1 only, ctx0 holds
    req = 2'b00; stall = 0; halt = 0; irq = 0; upd = 2'b10; nxt1 = 32'hABCD_0040;
    step();
    drive(2'b01, 2'b00, 2'b00, 2'b00);
    drive(2'b10, 2'b00, 2'b00, 2'b00);

    // R5: halt ctx0 -> ST1; R7: ctx0 never granted
    drive(2'b00, 2'b00, 2'b01, 2'b00);
    repeat (3) drive(2'b11, 2'b00, 2'b00, 2'b00);
    // R10: halt halted ctx0, irq running ctx1 -> no change
    drive(2'b11, 2'b00, 2'b01, 2'b10);
    // R6: irq to ctx0 -> MT
    drive(2'b11, 2'b00, 2'b00, 2'b01);
    // R5: double halt -> idle; R8: no grants
    drive(2'b11, 2'b00, 2'b11, 2'b00);
    drive(2'b11, 2'b00, 2'b00, 2'b00);
    // R8: irq ctx0 -> ST0, then ctx0 halts -> idle, then double irq -> MT
    drive(2'b00, 2'b00, 2'b00, 2'b01);
    drive(2'b11, 2'b00, 2'b01, 2'b00);
    drive(2'b11, 2'b00, 2'b00, 2'b11);
    drive(2'b11, 2'b00, 2'b00, 2'b00);

    // constrained random
    for (int n = 0; n < NCYC; n++) begin
      req   = 2'($urandom());
      stall = 2'($urandom()) & 2'($urandom());
      halt  = {($urandom() % 16) == 0, ($urandom() % 16) == 0};
      irq   = {($urandom() % 6) == 0, ($urandom() % 6) == 0};
      upd   = 2'($urandom());
      nxt0  = $urandom();
      nxt1  = $urandom();
      step();
    end
    finish_run();
  end
endmodule